// File: doc/BRIEF.md
# Address-Latched One-Hot Decoder

This block turns a six-bit address into a 64-wide one-hot output vector. The address can be captured in a level-controlled register placed in front of the decode logic. While the hold input is low, the register follows the address input, and the outputs decode the live address in the same cycle. Once hold is high, the register keeps the address it sampled at the last clock edge where hold was still low. Further address activity has no effect until hold drops again.

Inside, the block is two tiers of a three-bit latched decoder. One upper stage decodes the top three address bits. Each of its eight outputs acts as the enable of one lower stage, and each lower stage decodes the bottom three bits. All nine stages share the same hold control, so the whole address freezes together.

Two enables of opposite polarity gate the upper stage: an active-low enable and an active-high enable. When this gate is closed, all 64 outputs are low. The gate does not touch the stored address. A synchronous reset sets the stored address to zero.

Top module: `latchedOneHotDecoder`

## Requirements
- R1: With hold low and the output gate open, exactly the output whose index equals addrIn is high, in the same cycle. addrIn bit 0 is the least significant bit.
- R2: While hold is high, the output index is the address sampled at the last rising clock edge at which hold was low. Address changes during hold have no effect.
- R3: An address applied in the same cycle that hold rises is not captured. The held value is the one present at the clock edge before hold was raised.
- R4: The output gate is open only when enLowN is 0 and enHigh is 1. For each of the other three combinations, all 64 outputs are 0 whatever the address or hold state.
- R5: Closing the gate neither clears nor freezes the stored address. With hold low and the gate closed, the register still loads. After the gate reopens, the held address is decoded.
- R6: No more than one output is high at any time. While the gate is open, exactly one output is high.
- R7: A synchronous reset clears the stored address to 0. After reset with hold high and the gate open, only output 0 is high.
- R8: The upper three address bits pick one group of eight outputs and the lower three bits pick the output inside that group. Indices 0, 7, 8, 56 and 63 and every value in between decode to their own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address register |
| rst | input | 1 | Synchronous reset, active high; clears the stored address |
| addrIn | input | 6 | Address to decode; bit 0 is the least significant bit |
| holdAddr | input | 1 | 0: register loads and outputs follow addrIn; 1: stored address is kept |
| enLowN | input | 1 | Active-low output enable |
| enHigh | input | 1 | Active-high output enable |
| yOut | output | 64 | One-hot decoded outputs, active high |

## Verification
The embedded assertions check these properties on every cycle:
- at most one output is high, and exactly one while the gate is open;
- every closed-gate enable combination gives an all-zero vector;
- with hold low, the live address is decoded;
- with hold and the enables steady, the outputs stay stable.

Some behaviour can only be shown by the bench scenarios, because it depends on history:
- the value captured when hold rises in the same cycle as an address change;
- the address loaded while the gate was closed and seen only after it reopens;
- the zero address left by a reset taken with hold already high.

// File: rtl/ahdPkg.sv
package ahdPkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic loadAddr;   // address register follows its input this cycle
    logic outEnable;  // upper decode stage is gated open
  } ahdStrobes_t;

endpackage

// File: rtl/ahdCtrl.sv
module ahdCtrl
  import ahdPkg::*;
(
  input  logic        holdAddr,
  input  logic        enLowN,
  input  logic        enHigh,
  output ahdStrobes_t strobes
);

  always_comb begin
    strobes.loadAddr  = !holdAddr;
    strobes.outEnable = !enLowN && enHigh;
  end

endmodule

// File: rtl/ahdStage.sv
module ahdStage #(
  parameter int SEL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    loadAddr,
  input  logic                    stageEn,
  input  logic [SEL_W-1:0]        addrIn,
  output logic [(1<<SEL_W)-1:0]   yOut
);

  localparam int FAN = 1 << SEL_W;

  logic [SEL_W-1:0] addrQ;
  logic [SEL_W-1:0] effAddr;

  always_ff @(posedge clk) begin
    if (rst)           addrQ <= '0;
    else if (loadAddr) addrQ <= addrIn;
  end

  // Transparent while loading, stored value otherwise
  assign effAddr = loadAddr ? addrIn : addrQ;

  always_comb begin
    yOut = '0;
    if (stageEn) yOut[effAddr] = 1'b1;
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!loadAddr && $past(!loadAddr) && stageEn && $past(stageEn) && !$past(rst))
      |-> $stable(yOut)); // R2

endmodule

// File: rtl/ahdDatapath.sv
module ahdDatapath
  import ahdPkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ahdStrobes_t                   strobes,
  input  logic [2*SEL_W-1:0]            addrIn,
  output logic [(1<<(2*SEL_W))-1:0]     yOut
);

  localparam int FAN    = 1 << SEL_W;
  localparam int ADDR_W = 2 * SEL_W;

  logic [FAN-1:0] groupEn;

  // Upper tier: selects one group of outputs
  ahdStage #(.SEL_W(SEL_W)) u_upper (
    .clk      (clk),
    .rst      (rst),
    .loadAddr (strobes.loadAddr),
    .stageEn  (strobes.outEnable),
    .addrIn   (addrIn[ADDR_W-1 -: SEL_W]),
    .yOut     (groupEn)
  );

  // Lower tier: one stage per group, all sharing the hold control
  for (genvar g = 0; g < FAN; g++) begin : g_lower
    ahdStage #(.SEL_W(SEL_W)) u_lower (
      .clk      (clk),
      .rst      (rst),
      .loadAddr (strobes.loadAddr),
      .stageEn  (groupEn[g]),
      .addrIn   (addrIn[SEL_W-1:0]),
      .yOut     (yOut[g*FAN +: FAN])
    );
  end

  AST_TREE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(yOut)); // R6

  AST_OPEN_EXACTLY_ONE: assert property (@(posedge clk) disable iff (rst)
    strobes.outEnable |-> ($countones(yOut) == 1)); // R6

endmodule

// File: rtl/latchedOneHotDecoder.sv
module latchedOneHotDecoder
  import ahdPkg::*;
#(
  parameter int SEL_W  = 3,
  localparam int ADDR_W = 2 * SEL_W,
  localparam int OUT_N  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              holdAddr,
  input  logic              enLowN,
  input  logic              enHigh,
  output logic [OUT_N-1:0]  yOut
);

  ahdStrobes_t strobes;

  ahdCtrl u_ctrl (
    .holdAddr (holdAddr),
    .enLowN   (enLowN),
    .enHigh   (enHigh),
    .strobes  (strobes)
  );

  ahdDatapath #(.SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .addrIn  (addrIn),
    .yOut    (yOut)
  );

  AST_GATE_CLOSED_LOW: assert property (@(posedge clk) disable iff (rst)
    (enLowN || !enHigh) |-> (yOut == '0)); // R4

  AST_LIVE_INDEX: assert property (@(posedge clk) disable iff (rst)
    (!holdAddr && !enLowN && enHigh) |-> (yOut == (OUT_N'(1) << addrIn))); // R1

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (holdAddr && $past(holdAddr) && !$past(rst) && $stable(enLowN) && $stable(enHigh))
      |-> $stable(yOut)); // R2

endmodule

// File: tb/latchedOneHotDecoder_tb.sv
module latchedOneHotDecoder_tb;

  typedef struct {
    logic [63:0] expVec;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  addrIn;
  logic        holdAddr;
  logic        enLowN;
  logic        enHigh;
  logic [63:0] yOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  expItem_t expQ[$];
  logic [5:0] modelStored = 6'd0;
  event checkEv;

  always #4 clk = ~clk;  // 125 MHz

  latchedOneHotDecoder u_dut (
    .clk      (clk),
    .rst      (rst),
    .addrIn   (addrIn),
    .holdAddr (holdAddr),
    .enLowN   (enLowN),
    .enHigh   (enHigh),
    .yOut     (yOut)
  );

  // Driver: applies one cycle of stimulus and queues the expected vector
  task automatic drive(input logic r, input logic [5:0] a, input logic h,
                       input logic eln, input logic eh, input string tag);
    expItem_t it;
    logic [5:0] idx;
    @(negedge clk);
    rst = r; addrIn = a; holdAddr = h; enLowN = eln; enHigh = eh;
    idx = h ? modelStored : a;
    it.expVec = (!eln && eh) ? (64'd1 << idx) : 64'd0;
    it.tag = tag;
    expQ.push_back(it);
    #2;
    -> checkEv;
    @(posedge clk);
    if (r)       modelStored = 6'd0;
    else if (!h) modelStored = a;
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      expItem_t it;
      @(checkEv);
      if (expQ.size() != 0) begin
        it = expQ.pop_front();
        checks++;
        if (yOut !== it.expVec) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, yOut, it.expVec);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; addrIn = '0; holdAddr = 1'b0; enLowN = 1'b0; enHigh = 1'b1;
    // Reset cycles, transparent path
    drive(1, 6'd5, 0, 0, 1, "R1");
    drive(1, 6'd0, 0, 0, 1, "R1");
    // R8 boundaries through the transparent path
    drive(0, 6'd0,  0, 0, 1, "R8");
    drive(0, 6'd7,  0, 0, 1, "R8");
    drive(0, 6'd8,  0, 0, 1, "R8");
    drive(0, 6'd56, 0, 0, 1, "R8");
    drive(0, 6'd63, 0, 0, 1, "R8");
    drive(0, 6'd21, 0, 0, 1, "R1");
    // R3: hold rises in the same cycle as a new address
    drive(0, 6'd13, 0, 0, 1, "R1");
    drive(0, 6'd50, 1, 0, 1, "R3");
    drive(0, 6'd2,  1, 0, 1, "R2");
    drive(0, 6'd63, 1, 0, 1, "R2");
    // R4: each closed-gate combination, with the address held
    drive(0, 6'd40, 1, 1, 1, "R4");
    drive(0, 6'd40, 1, 1, 0, "R4");
    drive(0, 6'd40, 1, 0, 0, "R4");
    // R5: gate reopens on the old held address
    drive(0, 6'd9,  1, 0, 1, "R5");
    // R5: loading continues while the gate is closed
    drive(0, 6'd33, 0, 1, 0, "R4");
    drive(0, 6'd33, 0, 0, 0, "R4");
    drive(0, 6'd0,  1, 0, 1, "R5");
    drive(0, 6'd11, 1, 0, 1, "R2");
    // R7: reset taken with hold high clears the stored address
    drive(0, 6'd42, 0, 0, 1, "R1");
    drive(1, 6'd17, 1, 0, 1, "R7");
    drive(0, 6'd17, 1, 0, 1, "R7");
    drive(0, 6'd60, 1, 0, 1, "R7");
    // R8/R6: full sweep, each followed by a held cycle with another address
    for (int i = 0; i < 64; i++) begin
      drive(0, 6'(i), 0, 0, 1, "R8");
      drive(0, 6'(63 - i), 1, 0, 1, "R6");
    end
    drive(0, 6'd3, 0, 1, 0, "R6");
    #20;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule